// File: doc/BRIEF.md
# Automatic DAC Waveform Sequencer

This block feeds a 12-bit digital-to-analog converter with a stream of output codes. A small register port selects the operating mode. In automatic mode the block produces a square, triangle or sawtooth waveform with no software involvement. The output stays inside a programmable window set by a low limit and a high limit. A programmable divider sets how often the code advances. For the square wave, a hold count sets how many updates each level lasts. For the triangle and sawtooth, the limit window sets the period.

In manual mode, software or a DMA engine writes sample words into a small buffer. The block takes one word per divider step, clamps it into the limit window and presents it as the next code. A refill request is raised while the buffer fill is at or below a programmable level.

The block has two ways of applying a code. In immediate mode each new code goes to the output at once. In triggered mode a new code waits in a holding register and reaches the output only when an external trigger pulse arrives. Each change of the output is marked by a one-cycle update strobe.

Top module: `dac_wave_seq`

## Requirements
- R1: After reset the output code is 0, and both the update strobe and the refill request are low.
- R2: In immediate mode, consecutive update strobes are DIV+1 clock cycles apart, where DIV is the value written at register address 1.
- R3: Sawtooth (control shape field bits 3:2 = 2): the successive codes are LOW, LOW+1, …, HIGH, and then LOW again. LOW is held at address 2 and HIGH at address 3.
- R4: Triangle (shape = 1): the successive codes rise from LOW to HIGH one step at a time, then fall back to LOW, and turn around exactly at each limit.
- R5: Square (shape = 0 or 3): the code is HIGH for HOLD+1 updates and then LOW for HOLD+1 updates, where HOLD is held at address 4. The wave starts on the HIGH level.
- R6: When LOW is greater than HIGH, every update in automatic mode outputs LOW.
- R7: In manual mode (control bit 1 = 0), each divider step takes one word written at address 6. The word is clamped into [LOW, HIGH]. When the buffer is empty, no update occurs.
- R8: In triggered mode (control bit 4 = 1), the output changes only in the cycle after a trigger pulse, and only if a code is waiting. It takes the code that was waiting before that edge. If a new code arrives in the same cycle as the trigger, that new code becomes the next waiting code.
- R9: The refill request is high only while the block is enabled in manual mode and the buffer fill is at or below the level held at address 5. It follows one cycle behind these conditions.
- R10: Writes to a full buffer (8 words by default) are dropped.
- R11: While the enable bit (control bit 0) is low, no update strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 divider, 2 low limit, 3 high limit, 4 square hold, 5 refill level, 6 sample data |
| reg_wdata | input | 16 | Register write data |
| trig | input | 1 | Apply-trigger pulse used in triggered mode |
| dac_code | output | 12 | Current converter code |
| dac_upd | output | 1 | One-cycle strobe marking a change of dac_code |
| dma_req | output | 1 | Buffer refill request |

## Verification
In triggered mode, a fresh code from the generator and an external trigger can meet on the same clock edge. The bench runs a sawtooth with a long divider and counts cycles from the enabling write, so it knows the exact edge on which each new code lands in the holding register. It then places trigger pulses both between those edges and exactly on one of them. For the coinciding pulse, the bench expects the output to take the previous waiting code. It then expects the colliding code to be applied by the next trigger rather than lost. It also expects a second trigger with nothing waiting to leave the output unchanged.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    SHP_SQUARE = 2'd0,
    SHP_TRI    = 2'd1,
    SHP_SAW    = 2'd2,
    SHP_SQALT  = 2'd3
  } shape_e;

  typedef enum logic [REG_AW-1:0] {
    RS_CTRL  = 3'd0,
    RS_DIV   = 3'd1,
    RS_LOW   = 3'd2,
    RS_HIGH  = 3'd3,
    RS_HOLD  = 3'd4,
    RS_LEVEL = 3'd5,
    RS_DATA  = 3'd6,
    RS_NONE  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic   sync_md;
    shape_e shape;
    logic   auto_md;
    logic   en;
  } ctrl_t;

endpackage

// File: rtl/dac_rate_div.sv
module dac_rate_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             step
);

  logic [CNT_W-1:0] cnt_q;

  assign step = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dac_wave_core.sv
module dac_wave_core
  import dac_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              step,
  input  shape_e            shape,
  input  logic [CODE_W-1:0] lo,
  input  logic [CODE_W-1:0] hi,
  input  logic [HOLD_W-1:0] hold,
  output logic [CODE_W-1:0] code,
  output logic              code_vld
);

  logic [CODE_W-1:0] code_q;
  logic              vld_q;
  logic              first_q;
  logic              dir_up_q;
  logic              sq_hi_q;
  logic [HOLD_W-1:0] sq_cnt_q;

  assign code     = code_q;
  assign code_vld = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      vld_q    <= 1'b0;
      first_q  <= 1'b1;
      dir_up_q <= 1'b1;
      sq_hi_q  <= 1'b1;
      sq_cnt_q <= '0;
    end else if (!run) begin
      vld_q    <= 1'b0;
      first_q  <= 1'b1;
      dir_up_q <= 1'b1;
      sq_hi_q  <= 1'b1;
      sq_cnt_q <= '0;
    end else begin
      vld_q <= step;
      if (step) begin
        first_q <= 1'b0;
        if (lo > hi) begin
          code_q <= lo;
        end else begin
          unique case (shape)
            SHP_SAW: begin
              if (first_q || code_q >= hi || code_q < lo) code_q <= lo;
              else code_q <= code_q + CODE_W'(1);
            end
            SHP_TRI: begin
              if (first_q || code_q < lo || code_q > hi) begin
                code_q   <= lo;
                dir_up_q <= 1'b1;
              end else if (dir_up_q) begin
                if (code_q >= hi) begin
                  if (hi > lo) begin
                    code_q   <= code_q - CODE_W'(1);
                    dir_up_q <= 1'b0;
                  end
                end else begin
                  code_q <= code_q + CODE_W'(1);
                end
              end else begin
                if (code_q <= lo) begin
                  if (hi > lo) begin
                    code_q   <= code_q + CODE_W'(1);
                    dir_up_q <= 1'b1;
                  end
                end else begin
                  code_q <= code_q - CODE_W'(1);
                end
              end
            end
            default: begin
              code_q <= sq_hi_q ? hi : lo;
              if (sq_cnt_q == hold) begin
                sq_cnt_q <= '0;
                sq_hi_q  <= ~sq_hi_q;
              end else begin
                sq_cnt_q <= sq_cnt_q + HOLD_W'(1);
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dac_word_fifo.sv
module dac_word_fifo #(
  parameter int W  = 12,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [AW:0]  level
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q;
  logic [AW-1:0] rd_ptr_q;
  logic [AW:0]   lvl_q;
  logic          do_push;
  logic          do_pop;

  assign do_push = push && (lvl_q != (AW+1)'(DEPTH));
  assign do_pop  = pop && (lvl_q != '0);
  assign dout    = mem[rd_ptr_q];
  assign level   = lvl_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      unique case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + (AW+1)'(1);
        2'b01:   lvl_q <= lvl_q - (AW+1)'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sync_md,
  input  logic              cand_vld,
  input  logic [CODE_W-1:0] cand,
  input  logic              trig,
  output logic [CODE_W-1:0] code,
  output logic              upd
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] stage_q;
  logic              pend_q;
  logic              upd_q;

  assign code = code_q;
  assign upd  = upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (!run) begin
        pend_q <= 1'b0;
      end else if (!sync_md) begin
        pend_q <= 1'b0;
        if (cand_vld) begin
          code_q <= cand;
          upd_q  <= 1'b1;
        end
      end else begin
        if (trig && pend_q) begin
          code_q <= stage_q;
          upd_q  <= 1'b1;
        end
        if (cand_vld) begin
          stage_q <= cand;
          pend_q  <= 1'b1;
        end else if (trig) begin
          pend_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dac_wave_seq.sv
module dac_wave_seq
  import dac_seq_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int DATA_W  = 16,
  parameter int FIFO_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              trig,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_upd,
  output logic              dma_req
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] div_q;
  logic [CODE_W-1:0] lo_q;
  logic [CODE_W-1:0] hi_q;
  logic [DATA_W-1:0] hold_q;
  logic [FIFO_AW:0]  wm_q;

  logic              run;
  logic              auto_md;
  logic              sync_md;
  logic              step;
  logic              push;
  logic              pop;
  logic [CODE_W-1:0] fifo_dout;
  logic [FIFO_AW:0]  fifo_lvl;
  logic [CODE_W-1:0] wave_code;
  logic              wave_vld;
  logic [CODE_W-1:0] man_q;
  logic              man_vld_q;
  logic [CODE_W-1:0] cand;
  logic              cand_vld;
  logic              dma_q;

  function automatic logic [CODE_W-1:0] clip(input logic [CODE_W-1:0] x,
                                             input logic [CODE_W-1:0] l,
                                             input logic [CODE_W-1:0] h);
    if (l > h)      return l;
    else if (x < l) return l;
    else if (x > h) return h;
    else            return x;
  endfunction

  assign run     = ctrl_q.en;
  assign auto_md = ctrl_q.auto_md;
  assign sync_md = ctrl_q.sync_md;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '1;
      hold_q <= '0;
      wm_q   <= '0;
    end else if (reg_we) begin
      unique case (reg_sel_e'(reg_addr))
        RS_CTRL:  ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RS_DIV:   div_q  <= reg_wdata;
        RS_LOW:   lo_q   <= reg_wdata[CODE_W-1:0];
        RS_HIGH:  hi_q   <= reg_wdata[CODE_W-1:0];
        RS_HOLD:  hold_q <= reg_wdata;
        RS_LEVEL: wm_q   <= reg_wdata[FIFO_AW:0];
        default:  ;
      endcase
    end
  end

  assign push = reg_we && (reg_sel_e'(reg_addr) == RS_DATA);
  assign pop  = run && !auto_md && step && (fifo_lvl != '0);

  dac_rate_div #(.CNT_W(DATA_W)) div_i (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .limit(div_q),
    .step (step)
  );

  dac_wave_core #(.CODE_W(CODE_W), .HOLD_W(DATA_W)) wave_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run && auto_md),
    .step    (step),
    .shape   (ctrl_q.shape),
    .lo      (lo_q),
    .hi      (hi_q),
    .hold    (hold_q),
    .code    (wave_code),
    .code_vld(wave_vld)
  );

  dac_word_fifo #(.W(CODE_W), .AW(FIFO_AW)) fifo_i (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .din  (reg_wdata[CODE_W-1:0]),
    .pop  (pop),
    .dout (fifo_dout),
    .level(fifo_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      man_q     <= '0;
      man_vld_q <= 1'b0;
      dma_q     <= 1'b0;
    end else begin
      man_vld_q <= pop;
      if (pop) man_q <= clip(fifo_dout, lo_q, hi_q);
      dma_q <= run && !auto_md && (fifo_lvl <= wm_q);
    end
  end

  assign cand     = auto_md ? wave_code : man_q;
  assign cand_vld = auto_md ? wave_vld : man_vld_q;
  assign dma_req  = dma_q;

  dac_out_stage #(.CODE_W(CODE_W)) out_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .sync_md (sync_md),
    .cand_vld(cand_vld),
    .cand    (cand),
    .trig    (trig),
    .code    (dac_code),
    .upd     (dac_upd)
  );

endmodule

// File: rtl/dac_wave_seq_chk.sv
module dac_wave_seq_chk #(
  parameter int CODE_W  = 12,
  parameter int FIFO_AW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              auto_md,
  input logic              sync_md,
  input logic              trig,
  input logic              dac_upd,
  input logic [CODE_W-1:0] dac_code,
  input logic              dma_req,
  input logic [CODE_W-1:0] lo_q,
  input logic [CODE_W-1:0] hi_q,
  input logic [FIFO_AW:0]  fifo_lvl
);

  localparam int DEPTH = 1 << FIFO_AW;

  logic [1:0]        age_q;
  logic [CODE_W-1:0] lo_p1, lo_p2, hi_p1, hi_p2;
  logic              lim_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
    lo_p1 <= lo_q;
    lo_p2 <= lo_p1;
    hi_p1 <= hi_q;
    hi_p2 <= hi_p1;
  end

  assign lim_flat = (lo_q == lo_p1) && (lo_p1 == lo_p2) &&
                    (hi_q == hi_p1) && (hi_p1 == hi_p2);

  // R11
  upd_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    dac_upd |-> $past(run));

  // R8
  sync_needs_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_upd && $past(sync_md)) |-> $past(trig));

  // R9
  refill_mode_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(run && !auto_md));

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_lvl <= (FIFO_AW+1)'(DEPTH));

  // R7
  range_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_upd && !$past(sync_md) && age_q == 2'd3 && lim_flat && lo_q <= hi_q)
      |-> (dac_code >= lo_q && dac_code <= hi_q));

  // R6
  inverted_lim_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_upd && !$past(sync_md) && age_q == 2'd3 && lim_flat && lo_q > hi_q)
      |-> (dac_code == lo_q));

endmodule

bind dac_wave_seq dac_wave_seq_chk #(.CODE_W(CODE_W), .FIFO_AW(FIFO_AW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .auto_md (auto_md),
  .sync_md (sync_md),
  .trig    (trig),
  .dac_upd (dac_upd),
  .dac_code(dac_code),
  .dma_req (dma_req),
  .lo_q    (lo_q),
  .hi_q    (hi_q),
  .fifo_lvl(fifo_lvl)
);

// File: tb/dac_wave_seq_tb.sv
`timescale 1ns/1ps
module dac_wave_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        trig = 1'b0;
  logic [11:0] dac_code;
  logic        dac_upd;
  logic        dma_req;

  dac_wave_seq dut_i (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .trig     (trig),
    .dac_code (dac_code),
    .dac_upd  (dac_upd),
    .dma_req  (dma_req)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int got_v [1024];
  int got_t [1024];
  int ngot = 0;
  always @(negedge clk) begin
    if (!rst && dac_upd) begin
      if (ngot < 1024) begin
        got_v[ngot] = int'(dac_code);
        got_t[ngot] = cyc;
      end
      ngot = ngot + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int base = 0;
  int exp_v [256];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d[15:0];
    @(negedge clk);
    reg_we = 1'b0;
    base = cyc;
  endtask

  function automatic int cw(input bit en, input bit au, input int shp, input bit sy);
    return int'(en) | (int'(au) << 1) | ((shp & 3) << 2) | (int'(sy) << 4);
  endfunction

  function automatic void model(input int shape, input int lo, input int hi,
                                input int hold, input int n);
    int c = 0; bit up = 1; int sc = 0; bit sh = 1; bit first = 1;
    for (int i = 0; i < n; i++) begin
      if (lo > hi) c = lo;
      else if (shape == 2) begin
        if (first || c >= hi || c < lo) c = lo; else c = c + 1;
      end else if (shape == 1) begin
        if (first || c < lo || c > hi) begin c = lo; up = 1; end
        else if (up) begin
          if (c >= hi) begin if (hi > lo) begin c = c - 1; up = 0; end end
          else c = c + 1;
        end else begin
          if (c <= lo) begin if (hi > lo) begin c = c + 1; up = 1; end end
          else c = c - 1;
        end
      end else begin
        c = sh ? hi : lo;
        if (sc == hold) begin sc = 0; sh = !sh; end else sc = sc + 1;
      end
      first = 0;
      exp_v[i] = c;
    end
  endfunction

  task automatic run_auto(input int shape, input int lo, input int hi, input int dv,
                          input int hold, input int n, input string req);
    int s;
    wr(0, 0);
    repeat (3) @(negedge clk);
    wr(1, dv); wr(2, lo); wr(3, hi); wr(4, hold);
    model(shape, lo, hi, hold, n);
    #1 s = ngot;
    wr(0, cw(1, 1, shape, 0));
    repeat ((dv + 1) * (n + 1) + 4) @(negedge clk);
    wr(0, 0);
    #1;
    check(ngot - s >= n, {req, " update count"}, ngot - s, n);
    for (int i = 0; i < n; i++) begin
      check(got_v[s+i] == exp_v[i], req, got_v[s+i], exp_v[i]);
      if (i > 0)
        check(got_t[s+i] - got_t[s+i-1] == dv + 1, "R2 interval",
              got_t[s+i] - got_t[s+i-1], dv + 1);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    int s;
    int words [5];
    int clipped [5];
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dac_code == 12'd0, "R1 code", int'(dac_code), 0);
    check(dac_upd == 1'b0, "R1 upd", int'(dac_upd), 0);
    check(dma_req == 1'b0, "R1 dma", int'(dma_req), 0);

    // R3 sawtooth
    run_auto(2, 10, 14, 2, 0, 12, "R3 sawtooth");
    // R4 triangle
    run_auto(1, 100, 103, 1, 0, 12, "R4 triangle");
    // R5 square, both encodings
    run_auto(0, 5, 3000, 0, 2, 12, "R5 square");
    run_auto(3, 7, 900, 3, 1, 10, "R5 square alt");
    // R6 inverted limits
    run_auto(1, 50, 20, 1, 0, 8, "R6 triangle inverted");
    run_auto(0, 60, 10, 0, 1, 8, "R6 square inverted");

    // random mix
    for (int k = 0; k < 8; k++) begin
      int shp = int'($urandom % 4);
      int lo = int'($urandom % 40);
      int hi = lo + int'($urandom % 8);
      if (($urandom % 5) == 0 && lo > 0) hi = lo - 1;
      run_auto(shp, lo, hi, int'($urandom % 4), int'($urandom % 3), 16,
               (shp == 1) ? "R4 random" : (shp == 2) ? "R3 random" : "R5 random");
    end

    // R7 / R9 manual mode with clamping and refill request
    words = '{50, 500, 4000, 1000, 3000};
    clipped = '{100, 500, 3000, 1000, 3000};
    wr(0, 0); wr(1, 4); wr(2, 100); wr(3, 3000); wr(5, 2);
    for (int i = 0; i < 5; i++) wr(6, words[i]);
    repeat (2) @(negedge clk);
    check(dma_req == 1'b0, "R9 disabled", int'(dma_req), 0);
    #1 s = ngot;
    wr(0, cw(1, 0, 0, 0));
    repeat (2) @(negedge clk);
    check(dma_req == 1'b0, "R9 fill above level", int'(dma_req), 0);
    repeat (60) @(negedge clk);
    #1;
    check(ngot - s == 5, "R7 one update per word, none when empty", ngot - s, 5);
    for (int i = 0; i < 5; i++) begin
      check(got_v[s+i] == clipped[i], "R7 clamped word", got_v[s+i], clipped[i]);
      if (i > 0)
        check(got_t[s+i] - got_t[s+i-1] == 5, "R2 manual interval",
              got_t[s+i] - got_t[s+i-1], 5);
    end
    check(dma_req == 1'b1, "R9 fill at or below level", int'(dma_req), 1);
    wr(0, 0);
    repeat (2) @(negedge clk);
    check(dma_req == 1'b0, "R9 after disable", int'(dma_req), 0);

    // R10 overflow drops writes
    for (int i = 0; i < 10; i++) wr(6, 200 + 7 * i);
    #1 s = ngot;
    wr(0, cw(1, 0, 0, 0));
    repeat (80) @(negedge clk);
    wr(0, 0);
    #1;
    check(ngot - s == 8, "R10 count", ngot - s, 8);
    for (int i = 0; i < 8; i++)
      check(got_v[s+i] == 200 + 7 * i, "R10 kept word", got_v[s+i], 200 + 7 * i);

    // R8 triggered mode; staging edges at base+17+16j, saw 0..3
    wr(1, 15); wr(2, 0); wr(3, 3);
    repeat (3) @(negedge clk);
    #1 s = ngot;
    wr(0, cw(1, 1, 2, 1));
    wait_cyc(base + 40);
    #1;
    check(ngot == s, "R8 no update without trigger", ngot - s, 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    check(dac_upd == 1'b1, "R8 trigger applies", int'(dac_upd), 1);
    check(dac_code == 12'd1, "R8 latest waiting code", int'(dac_code), 1);
    wait_cyc(base + 42);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    check(dac_upd == 1'b0, "R8 nothing waiting", int'(dac_upd), 0);
    check(dac_code == 12'd1, "R8 code held", int'(dac_code), 1);
    wait_cyc(base + 64);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    check(dac_code == 12'd2, "R8 collision applies older code", int'(dac_code), 2);
    wait_cyc(base + 70);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    check(dac_code == 12'd3, "R8 colliding code kept", int'(dac_code), 3);
    check(dac_upd == 1'b1, "R8 second apply strobe", int'(dac_upd), 1);

    // R11 disabled: no strobes even with triggers
    wr(0, 0);
    repeat (3) @(negedge clk);
    #1 s = ngot;
    for (int i = 0; i < 5; i++) begin
      trig = 1'b1; @(negedge clk); trig = 1'b0;
      repeat (5) @(negedge clk);
    end
    #1;
    check(ngot == s, "R11 no updates while disabled", ngot - s, 0);
    check(dac_code == 12'd3, "R11 code unchanged", int'(dac_code), 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule